// File: doc/BRIEF.md
# Paged Address Translator with Fault Capture

This block turns a 32-bit virtual address into a physical address in one cycle. It looks the address up in one of two translation caches: one for instruction fetches and one for data loads and stores. Each cache has four ways of sixteen entries and maps 8 KiB pages. An entry hits when its page number matches and either it is marked global or its process tag equals the current process ID. A hit then passes through a chain of permission checks. Software switches each check on or off with a four-bit enable word.

The block reports a physical address and a read/write/execute permission mask. If the translation fails, it instead reports a fault flag and an exception vector. On a committed fault it records the context in two registers. The cause register holds the process, the access kind and the page number. The selection register holds the index and way that refill software should overwrite. On each committed fault it also steps a 16-bit feedback shift register, which supplies a pseudo-random way for refills. Software fills entries through a single write port. A debug lookup reports its result but changes no state.

Top module: `tlb_xlate`

## Requirements
- R1: The page number is vaddr[31:13] and the index is vaddr[16:13]. An entry hits when its page number equals the address page number and either its global bit is set or its tag PID equals `cur_pid`. If several ways hit, the lowest-numbered way wins. On success `rsp_paddr` = {frame, vaddr[12:0]}. On a fault `rsp_paddr` and `rsp_prot` are 0.
- R2: The tag word carries the page number in [31:13] and the PID in [7:0]. The data word carries the frame in [31:13], global in 4, valid in 3, kernel in 2, write in 1 and execute in 0. `wr_en` stores both words at (`wr_instr`, `wr_way`, `wr_idx`), and the entry is visible from the next cycle.
- R3: `req_kind` is coded 0 = load, 1 = store, 2 = fetch. A fetch uses only the instruction cache, with vector base 4. Loads and stores use only the data cache, with vector base 8.
- R4: A lookup that hits no way faults with vector base+0.
- R5: A hit is checked in this priority order, using the enable bits `chk_en[3]` write, `[2]` kernel, `[1]` execute and `[0]` valid. (a) Kernel enable, entry kernel bit and `req_user` all set gives base+2. (b) A store to an entry without write permission, with write enable set, gives base+3. (c) A fetch from an entry without execute permission, with execute enable set, gives base+3. (d) An entry with valid clear, with valid enable set, gives base+1. Otherwise the lookup succeeds.
- R6: On success `rsp_prot` bit 0 (read) is 1 and bit 1 (write) equals the entry's write bit. Bit 2 (execute) is 1 only for a fetch, and only if `chk_en[1]` or the entry's execute bit is set.
- R7: A committed fault loads `fault_sel` with the index in [3:0] and the way in [5:4]. The way is the hitting way for a protection fault, or `lfsr_state[1:0]` as it stood before the step for a miss.
- R8: A committed fault writes `fault_cause` with `cur_pid` in [7:0], the kind code (0 read, 1 write, 2 execute) in [9:8] and the page number in [31:13]. Bits [12:10] keep their value.
- R9: On each committed fault `lfsr_state` shifts right by one, and bit 15 takes the parity of (state AND 0x8805).
- R10: A fault commits only when `req_valid` is 1 and `req_debug` is 0. Otherwise the three registers hold, and without `req_valid` no fault is flagged.
- R11: After reset `lfsr_state` = 0xCCCC, `fault_sel` = 0, `fault_cause` = 0 and every entry is all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_instr | input | 1 | 1 selects the instruction cache for the write |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Index to write |
| wr_tag | input | 32 | Tag word |
| wr_data | input | 32 | Data word |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | User-mode access |
| req_debug | input | 1 | Side-effect-free lookup |
| cur_pid | input | 8 | Current process ID |
| chk_en | input | 4 | Check enables: write, kernel, execute, valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_prot | output | 3 | Permissions: exec, write, read |
| rsp_fault | output | 1 | Miss or protection fault |
| rsp_vector | output | 4 | Exception vector |
| fault_sel | output | 6 | Refill way and index |
| fault_cause | output | 32 | Captured fault context |
| lfsr_state | output | 16 | Refill randomiser state |

## Verification
The bench targets fault priority. It builds an entry that breaks the kernel, write and valid rules all at once and clears the conditions one at a time. A design with the checks in the wrong order would report vector 11 or 9 where 10 is due. It also targets the choice of cache. The same page is present in the instruction cache but missing from the data cache, so mixing up the arrays shows up as a hit where a miss is due, or as the wrong vector base. Two global entries in one set show whether the lowest way wins. A design that instead keeps the last matching way returns the wrong frame. Debug and idle lookups that would fault show whether the cause, select and LFSR registers stay unchanged. Each committed fault is compared against a step-by-step model of the LFSR, which catches a wrong tap mask or a way sampled after the step.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 13;
    parameter int NUM_WAYS  = 4;
    parameter int NUM_SETS  = 16;
    parameter int PID_W     = 8;
    parameter int RND_W     = 16;
    parameter logic [15:0] RND_SEED = 16'hCCCC;
    parameter logic [15:0] RND_TAPS = 16'h8805;

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int SEL_W = IDX_W + WAY_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic [VPN_W-1:0]           vpn;
        logic [PAGE_BITS-PID_W-1:0] pad;
        logic [PID_W-1:0]           pid;
    } tag_t;

    typedef struct packed {
        logic [VPN_W-1:0]     pfn;
        logic [PAGE_BITS-6:0] pad;
        logic                 glob;
        logic                 vld;
        logic                 kern;
        logic                 wr;
        logic                 ex;
    } data_t;

    typedef struct packed {
        logic             hit;
        logic [WAY_W-1:0] way;
        logic             fault;
        logic [1:0]       voff;
        logic [2:0]       prot;
        logic [VPN_W-1:0] pfn;
    } lkp_t;

    function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] s);
        return {^(s & RND_TAPS[RND_W-1:0]), s[RND_W-1:1]};
    endfunction

    function automatic logic [1:0] kind_code(input logic [1:0] k);
        case (k)
            ACC_STORE: return 2'd1;
            ACC_FETCH: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_xlate_store.sv
module tlb_xlate_store
    import tlb_xlate_pkg::*;
#(
    parameter int N_WAYS = NUM_WAYS,
    parameter int N_SETS = NUM_SETS,
    localparam int WSEL = $clog2(N_WAYS),
    localparam int ISEL = $clog2(N_SETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WSEL-1:0] wr_way,
    input  logic [ISEL-1:0] wr_idx,
    input  tag_t            wr_tag,
    input  data_t           wr_data,
    input  logic [ISEL-1:0] rd_idx,
    output tag_t            rd_tag  [N_WAYS],
    output data_t           rd_data [N_WAYS]
);
    for (genvar w = 0; w < N_WAYS; w++) begin : g_way
        tag_t  tag_mem [N_SETS];
        data_t dat_mem [N_SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < N_SETS; s++) begin
                    tag_mem[s] <= '0;
                    dat_mem[s] <= '0;
                end
            end else if (wr_en && wr_way == WSEL'(w)) begin
                tag_mem[wr_idx] <= wr_tag;
                dat_mem[wr_idx] <= wr_data;
            end
        end

        assign rd_tag[w]  = tag_mem[rd_idx];
        assign rd_data[w] = dat_mem[rd_idx];
    end
endmodule

// File: rtl/tlb_xlate_check.sv
module tlb_xlate_check
    import tlb_xlate_pkg::*;
(
    input  tag_t             tags  [NUM_WAYS],
    input  data_t            datas [NUM_WAYS],
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    input  logic [1:0]       kind,
    input  logic             user,
    input  logic [3:0]       en,
    output lkp_t             res
);
    data_t ent;
    logic  en_w, en_k, en_x, en_v;
    logic  is_fetch;

    assign {en_w, en_k, en_x, en_v} = en;
    assign is_fetch = (kind == ACC_FETCH);

    always_comb begin
        res = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!res.hit && tags[w].vpn == vpn &&
                (datas[w].glob || tags[w].pid == pid)) begin
                res.hit = 1'b1;
                res.way = WAY_W'(w);
            end
        end
        ent       = datas[res.way];
        res.fault = 1'b1;
        if (res.hit) begin
            if (en_k && ent.kern && user)
                res.voff = 2'd2;
            else if (kind == ACC_STORE && en_w && !ent.wr)
                res.voff = 2'd3;
            else if (is_fetch && en_x && !ent.ex)
                res.voff = 2'd3;
            else if (en_v && !ent.vld)
                res.voff = 2'd1;
            else begin
                res.fault = 1'b0;
                res.prot  = {is_fetch && (en_x || ent.ex), ent.wr, 1'b1};
                res.pfn   = ent.pfn;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_lfsr.sv
module tlb_xlate_lfsr
    import tlb_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [RND_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)      state <= RND_SEED[RND_W-1:0];
        else if (adv) state <= rnd_next(state);
    end

    // R9
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

    // R9
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> state[RND_W-2:0] == $past(state[RND_W-1:1]));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_instr,
    input  logic [1:0]  wr_way,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_tag,
    input  logic [31:0] wr_data,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        req_user,
    input  logic        req_debug,
    input  logic [7:0]  cur_pid,
    input  logic [3:0]  chk_en,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_prot,
    output logic        rsp_fault,
    output logic [3:0]  rsp_vector,
    output logic [5:0]  fault_sel,
    output logic [31:0] fault_cause,
    output logic [15:0] lfsr_state
);
    localparam int N_ARR = 2;

    logic [VPN_W-1:0] vpn;
    logic [IDX_W-1:0] idx;
    logic             is_fetch;
    lkp_t             lkp;
    logic             commit;
    tag_t             arr_tag  [N_ARR][NUM_WAYS];
    data_t            arr_data [N_ARR][NUM_WAYS];
    tag_t             sel_tag  [NUM_WAYS];
    data_t            sel_data [NUM_WAYS];

    assign vpn      = req_vaddr[VA_W-1:PAGE_BITS];
    assign idx      = vpn[IDX_W-1:0];
    assign is_fetch = (req_kind == ACC_FETCH);

    // array 0 = data, array 1 = instruction
    for (genvar a = 0; a < N_ARR; a++) begin : g_arr
        tlb_xlate_store u_store (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (wr_instr == (a == 1))),
            .wr_way  (wr_way),
            .wr_idx  (wr_idx),
            .wr_tag  (tag_t'(wr_tag)),
            .wr_data (data_t'(wr_data)),
            .rd_idx  (idx),
            .rd_tag  (arr_tag[a]),
            .rd_data (arr_data[a])
        );
    end

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            sel_tag[w]  = arr_tag[int'(is_fetch)][w];
            sel_data[w] = arr_data[int'(is_fetch)][w];
        end
    end

    tlb_xlate_check u_check (
        .tags  (sel_tag),
        .datas (sel_data),
        .vpn   (vpn),
        .pid   (cur_pid),
        .kind  (req_kind),
        .user  (req_user),
        .en    (chk_en),
        .res   (lkp)
    );

    assign commit = req_valid && lkp.fault && !req_debug;

    tlb_xlate_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (commit),
        .state (lfsr_state)
    );

    assign rsp_fault  = req_valid && lkp.fault;
    assign rsp_prot   = req_valid ? lkp.prot : 3'b000;
    assign rsp_paddr  = lkp.fault ? '0 : {lkp.pfn, req_vaddr[PAGE_BITS-1:0]};
    assign rsp_vector = (is_fetch ? 4'd4 : 4'd8) + {2'b00, lkp.voff};

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_sel   <= '0;
            fault_cause <= '0;
        end else if (commit) begin
            fault_sel <= {(lkp.hit ? lkp.way : lfsr_state[WAY_W-1:0]), idx};
            fault_cause <= {vpn, fault_cause[PAGE_BITS-1:PID_W+2],
                            kind_code(req_kind), cur_pid};
        end
    end

    // R6
    prot_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_prot == 3'b000 && rsp_paddr == '0);

    // R6
    read_granted_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_fault) |-> rsp_prot[0]);

    // R3
    no_data_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_fetch) |-> !rsp_prot[2]);

    // R3
    vector_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_vector[3:2] == (is_fetch ? 2'b01 : 2'b10));

    // R7
    sel_index_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> fault_sel[IDX_W-1:0] == $past(req_vaddr[PAGE_BITS+IDX_W-1:PAGE_BITS]));

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(fault_cause) && $stable(fault_sel));
endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_instr;
    logic [1:0]  wr_way;
    logic [3:0]  wr_idx;
    logic [31:0] wr_tag, wr_data;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_user, req_debug;
    logic [7:0]  cur_pid;
    logic [3:0]  chk_en;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_prot;
    logic        rsp_fault;
    logic [3:0]  rsp_vector;
    logic [5:0]  fault_sel;
    logic [31:0] fault_cause;
    logic [15:0] lfsr_state;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] m_lfsr;
    logic [5:0]  m_sel;
    logic [31:0] m_cause;

    always #2.5 clk = ~clk;

    tlb_xlate uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] s);
        logic p = 1'b0;
        for (int i = 0; i < 16; i++)
            if (((16'h8805 >> i) & 16'h1) != 0) p = p ^ s[i];
        return {p, s[15:1]};
    endfunction

    function automatic logic [31:0] mk_tag(input logic [18:0] vpn, input logic [7:0] pid);
        return {vpn, 5'b0, pid};
    endfunction

    function automatic logic [31:0] mk_data(input logic [18:0] pfn, input logic g,
        input logic v, input logic k, input logic w, input logic x);
        return {pfn, 8'b0, g, v, k, w, x};
    endfunction

    task automatic put(input logic instr, input logic [1:0] way, input logic [3:0] idx,
                       input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_instr = instr; wr_way = way; wr_idx = idx;
        wr_tag = t; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // exp_way < 0: miss
    task automatic look(input string req, input logic valid, input logic [31:0] va,
        input logic [1:0] kind, input logic user, input logic dbg, input logic [3:0] en,
        input logic e_fault, input logic [3:0] e_vec, input logic [31:0] e_pa,
        input logic [2:0] e_prot, input int e_way);
        @(negedge clk);
        req_valid = valid; req_vaddr = va; req_kind = kind; req_user = user;
        req_debug = dbg; chk_en = en;
        #1;
        chk(rsp_fault == e_fault, {req, " fault"}, 32'(rsp_fault), 32'(e_fault));
        if (e_fault) chk(rsp_vector == e_vec, {req, " vector"}, 32'(rsp_vector), 32'(e_vec));
        chk(rsp_paddr == e_pa, {req, " paddr"}, rsp_paddr, e_pa);
        chk(rsp_prot == e_prot, {req, " prot"}, 32'(rsp_prot), 32'(e_prot));
        if (valid && e_fault && !dbg) begin
            m_sel   = {(e_way < 0 ? m_lfsr[1:0] : 2'(e_way)), va[16:13]};
            m_cause = {va[31:13], m_cause[12:10], (kind == 2'd1 ? 2'd1 : kind == 2'd2 ? 2'd2 : 2'd0), cur_pid};
            m_lfsr  = m_step(m_lfsr);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(fault_sel == m_sel, {req, " R7 select"}, 32'(fault_sel), 32'(m_sel));
        chk(fault_cause == m_cause, {req, " R8 cause"}, fault_cause, m_cause);
        chk(lfsr_state == m_lfsr, {req, " R9 lfsr"}, 32'(lfsr_state), 32'(m_lfsr));
    endtask

    task automatic t_reset;
        chk(lfsr_state == 16'hCCCC, "R11 lfsr", 32'(lfsr_state), 32'hCCCC);
        chk(fault_sel == 6'd0, "R11 sel", 32'(fault_sel), 0);
        chk(fault_cause == 32'd0, "R11 cause", fault_cause, 0);
    endtask

    task automatic t_miss;
        cur_pid = 8'h5A;
        look("R4 data miss", 1, 32'h0004_6000, 2'd0, 0, 0, 4'h0, 1, 4'd8, 0, 0, -1);
        look("R4 second miss", 1, 32'h0004_6000, 2'd1, 0, 0, 4'h0, 1, 4'd8, 0, 0, -1);
    endtask

    task automatic t_global;
        put(0, 2'd2, 4'd3, mk_tag(19'h23, 8'h11), mk_data(19'h155, 1, 1, 0, 1, 1));
        look("R1 global hit", 1, 32'h0004_6ABC, 2'd0, 0, 0, 4'h2, 0, 4'd0, 32'h002A_AABC, 3'b011, 0);
    endtask

    task automatic t_pid;
        put(0, 2'd1, 4'd5, mk_tag(19'h45, 8'h5A), mk_data(19'h7, 0, 1, 0, 0, 0));
        look("R1 pid hit", 1, 32'h0008_A010, 2'd0, 0, 0, 4'h0, 0, 4'd0, 32'h0000_E010, 3'b001, 0);
        cur_pid = 8'h5B;
        look("R1 pid mismatch", 1, 32'h0008_A010, 2'd0, 0, 0, 4'h0, 1, 4'd8, 0, 0, -1);
        cur_pid = 8'h5A;
    endtask

    task automatic t_priority;
        put(0, 2'd0, 4'd6, mk_tag(19'h26, 8'h5A), mk_data(19'h33, 0, 0, 1, 0, 0));
        look("R5 kernel first", 1, 32'h0004_C000, 2'd1, 1, 0, 4'hF, 1, 4'd10, 0, 0, 0);
        look("R5 write next", 1, 32'h0004_C000, 2'd1, 0, 0, 4'hF, 1, 4'd11, 0, 0, 0);
        look("R5 invalid last", 1, 32'h0004_C000, 2'd0, 0, 0, 4'hF, 1, 4'd9, 0, 0, 0);
        look("R5 R6 checks off", 1, 32'h0004_C004, 2'd1, 1, 0, 4'h0, 0, 4'd0, 32'h0006_6004, 3'b001, 0);
    endtask

    task automatic t_exec;
        put(1, 2'd3, 4'd7, mk_tag(19'h27, 8'h5A), mk_data(19'h40, 0, 1, 0, 0, 0));
        look("R5 exec fault", 1, 32'h0004_E000, 2'd2, 0, 0, 4'h2, 1, 4'd7, 0, 0, 3);
        look("R6 no exec", 1, 32'h0004_E008, 2'd2, 0, 0, 4'h0, 0, 4'd0, 32'h0008_0008, 3'b001, 0);
        put(1, 2'd3, 4'd7, mk_tag(19'h27, 8'h5A), mk_data(19'h40, 0, 1, 0, 0, 1));
        look("R6 exec grant", 1, 32'h0004_E008, 2'd2, 0, 0, 4'h2, 0, 4'd0, 32'h0008_0008, 3'b101, 0);
        look("R3 data array separate", 1, 32'h0004_E008, 2'd0, 0, 0, 4'h2, 1, 4'd8, 0, 0, -1);
    endtask

    task automatic t_lowest;
        put(0, 2'd3, 4'd9, mk_tag(19'h29, 8'h00), mk_data(19'h22, 1, 1, 0, 0, 0));
        put(0, 2'd1, 4'd9, mk_tag(19'h29, 8'h00), mk_data(19'h11, 1, 1, 0, 0, 0));
        look("R1 lowest way", 1, 32'h0005_2000, 2'd0, 0, 0, 4'h0, 0, 4'd0, 32'h0002_2000, 3'b001, 0);
        look("R2 rewrite visible", 1, 32'h0005_2000, 2'd0, 0, 0, 4'h1, 0, 4'd0, 32'h0002_2000, 3'b001, 0);
    endtask

    task automatic t_quiet;
        look("R10 debug fault", 1, 32'h00F0_0000, 2'd1, 0, 1, 4'h0, 1, 4'd8, 0, 0, -1);
        look("R10 idle", 0, 32'h00F0_0000, 2'd1, 0, 0, 4'h0, 0, 4'd0, 0, 0, -1);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                $display("FAIL watchdog R10 actual=%0d expected=<20000", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_instr = 0; wr_way = 0; wr_idx = 0;
        wr_tag = 0; wr_data = 0; req_valid = 0; req_vaddr = 0; req_kind = 0;
        req_user = 0; req_debug = 0; cur_pid = 0; chk_en = 0;
        m_lfsr = 16'hCCCC; m_sel = 0; m_cause = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_miss();
        t_global();
        t_pid();
        t_priority();
        t_exec();
        t_lowest();
        t_quiet();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule